// File: doc/BRIEF.md
# Ring Halt and Stop Controller

This block is the control slice of a DMA engine that serves eight transmit rings and eight receive rings. It owns the per-ring base and current-descriptor pointer registers, the halt flags of every ring, and a three-bit control register. It turns register writes and a periodic poll into ring-walk requests, which it hands to the descriptor walkers. It also reports when a graceful stop of either direction has taken effect.

Software reaches the block through a single-cycle write port and a combinational read port. A write of 1 to a halt flag clears the flag and may start a walk of that ring. Walk requests are collected in a pending mask per direction. Each mask issues one ring index per cycle, lowest ring first. A graceful stop that is requested while a frame is in flight completes when that frame ends. When its hold bit is clear, the poll timer requests a walk of transmit ring 0 once per poll period.

Top module: `ring_halt_ctrl`

## Requirements
- R1: A write to a base register (tx ring i at address i, rx ring i at address 8+i) stores the data with bits [2:0] forced to 0, and reading the same address returns that value. Unmapped addresses read as 0.
- R2: A base write also loads the same aligned value into the ring's pointer register (tx ring i at address 16+i, rx ring i at address 24+i). Writes to pointer addresses are ignored.
- R3: A write to the tx status register (address 32) with bit (31-i) set requests a walk of tx ring i, whatever the state of that ring's halt flag.
- R4: A write to the rx status register (address 33) with bit (23-i) set requests a walk of rx ring i only when that ring's halt flag was clear before the write.
- R5: Halt flags are set by the tx_halt_set and rx_halt_set pulses and read back at bit (31-i) (tx) and bit (23-i) (rx). Every flag written as 1 is cleared.
- R6: Pending walk requests are issued one per cycle, lowest ring first. The first request appears on the walk outputs one cycle after the edge that sampled the write.
- R7: Writing the control register (address 34) with the rx stop bit (bit 1) set pulses rx_stop_done one cycle later if rx_busy is low. Otherwise the pulse comes one cycle after rx_busy falls.
- R8: The tx stop bit (bit 2) works the same way with tx_busy and tx_stop_done.
- R9: A control write with the hold bit (bit 0) clear restarts the poll timer. A walk of tx ring 0 then appears POLL_PERIOD+1 cycles after the write edge, and again every POLL_PERIOD cycles after that.
- R10: While the tx stop bit is set, poll expiries issue no walk and the timer keeps running.
- R11: If the hold bit is set when the timer expires, the timer stops and no walk is issued.
- R12: After reset every register, flag and output is 0, and the poll timer is idle until a control write with the hold bit clear.
- R13: A poll expiry and a tx status write of ring 0 that land on the same edge give a single walk of ring 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tx_halt_set | input | 8 | Per-ring pulses that set tx halt flags |
| rx_halt_set | input | 8 | Per-ring pulses that set rx halt flags |
| tx_busy | input | 1 | A transmit frame is in progress |
| rx_busy | input | 1 | A receive frame is in progress |
| tx_walk_valid | output | 1 | Tx ring walk request |
| tx_walk_ring | output | 3 | Tx ring index for the request |
| rx_walk_valid | output | 1 | Rx ring walk request |
| rx_walk_ring | output | 3 | Rx ring index for the request |
| tx_stop_done | output | 1 | Tx graceful stop complete pulse |
| rx_stop_done | output | 1 | Rx graceful stop complete pulse |

## Verification
The poll timer and a software kick of transmit ring 0 both feed bit 0 of the same pending mask, so they can arrive on the same clock edge. The bench restarts the timer and counts edges so that a tx status write of ring 0 is sampled on the edge where the timer expires. It then expects exactly one walk of ring 0 in the cycles that follow. Separately, multi-bit status writes check that the pending mask drains in ascending ring order.

// File: rtl/hs_pkg.sv
// Shared constants for the ring halt and stop controller.
// Assumes 32-bit registers and eight rings per direction; the halt-flag
// bit positions are tied to that layout.
package hs_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 6;
    localparam int RING_CNT = 8;
    localparam int RING_W   = $clog2(RING_CNT);

    localparam int TX_HALT_MSB = 31;
    localparam int RX_HALT_MSB = 23;

    localparam logic [ADDR_W-1:0] A_TX_BASE = 6'd0;
    localparam logic [ADDR_W-1:0] A_RX_BASE = A_TX_BASE + ADDR_W'(RING_CNT);
    localparam logic [ADDR_W-1:0] A_TX_PTR  = A_RX_BASE + ADDR_W'(RING_CNT);
    localparam logic [ADDR_W-1:0] A_RX_PTR  = A_TX_PTR + ADDR_W'(RING_CNT);
    localparam logic [ADDR_W-1:0] A_TX_STAT = A_RX_PTR + ADDR_W'(RING_CNT);
    localparam logic [ADDR_W-1:0] A_RX_STAT = A_TX_STAT + 6'd1;
    localparam logic [ADDR_W-1:0] A_CTRL    = A_TX_STAT + 6'd2;

    localparam int CTL_W = 3;

    // Control register: bit0 hold poll, bit1 rx soft stop, bit2 tx soft stop
    typedef struct packed {
        logic tx_stop;
        logic rx_stop;
        logic hold;
    } ctl_t;
endpackage

// File: rtl/hs_ring_base.sv
// Base and current-pointer registers for one direction's rings.
// A write to ring i stores the data, aligned to 8 bytes, in both the base
// and the pointer of ring i. Assumes wr_idx is valid while wr_en is high.
module hs_ring_base #(
    parameter int RINGS = 8,
    parameter int DW    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(RINGS)-1:0]   wr_idx,
    input  logic [DW-1:0]              wr_data,
    output logic [RINGS-1:0][DW-1:0]   base_o,
    output logic [RINGS-1:0][DW-1:0]   ptr_o
);
    localparam int RW = $clog2(RINGS);
    localparam logic [DW-1:0] ALIGN_MASK = ~{{(DW-3){1'b0}}, 3'b111};

    for (genvar g = 0; g < RINGS; g++) begin : g_ring
        // Store the aligned base and copy it to the ring's pointer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[g] <= '0;
                ptr_o[g]  <= '0;
            end else if (wr_en && wr_idx == RW'(g)) begin
                base_o[g] <= wr_data & ALIGN_MASK;
                ptr_o[g]  <= wr_data & ALIGN_MASK;
            end
        end

        AST_PTR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == RW'(g)) |=> (ptr_o[g] == base_o[g])); // R2
    end
endmodule

// File: rtl/hs_walk_queue.sv
// Pending mask of ring-walk requests for one direction.
// New requests are ORed into the mask. Each cycle the lowest pending ring
// is issued on registered outputs and its bit is cleared.
module hs_walk_queue #(
    parameter int RINGS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [RINGS-1:0]          req,
    output logic                      walk_valid,
    output logic [$clog2(RINGS)-1:0]  walk_ring
);
    localparam int RW = $clog2(RINGS);

    logic [RINGS-1:0] pend_q;
    logic [RINGS-1:0] pick_oh;
    logic [RW-1:0]    pick_idx;

    // Find the lowest pending ring.
    always_comb begin
        pick_idx = '0;
        for (int i = RINGS - 1; i >= 0; i--) begin
            if (pend_q[i]) pick_idx = RW'(i);
        end
        pick_oh = (|pend_q) ? (RINGS'(1) << pick_idx) : '0;
    end

    // Retire the issued ring, merge new requests, register the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= '0;
            walk_valid <= 1'b0;
            walk_ring  <= '0;
        end else begin
            pend_q     <= (pend_q & ~pick_oh) | req;
            walk_valid <= |pend_q;
            walk_ring  <= pick_idx;
        end
    end

    AST_WALK_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_q) |=> walk_valid); // R6
endmodule

// File: rtl/hs_stop_track.sv
// Graceful stop completion for one direction.
// A stop request made while no frame is in flight completes on the next
// edge. Otherwise it is held and completes once busy is seen low. Writing
// the stop bit as 0 drops a held request.
module hs_stop_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic stop_bit,
    input  logic busy,
    output logic done_o
);
    logic pend_q;

    // Decide between immediate and deferred completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (ctrl_wr && stop_bit) begin
                done_o <= !busy;
                pend_q <= busy;
            end else if (ctrl_wr) begin
                pend_q <= 1'b0;
            end else if (pend_q && !busy) begin
                done_o <= 1'b1;
                pend_q <= 1'b0;
            end
        end
    end

    AST_STOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !$past(busy)); // R7 (also R8)
endmodule

// File: rtl/hs_poll_timer.sv
// Periodic transmit ring-0 poll timer.
// A control write with hold clear reloads it for one full period. At each
// expiry it requests a poll unless hold or tx stop is set. It re-arms
// while hold is clear and goes idle if hold is set. Needs PERIOD >= 2.
module hs_poll_timer #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic hold_new,
    input  logic hold_q,
    input  logic tx_stop_q,
    output logic poll_req
);
    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    // Expiry and request qualification.
    always_comb begin
        expire   = active_q && (cnt_q == '0);
        poll_req = expire && !hold_q && !tx_stop_q;
    end

    // Count down, reload on restart or expiry, stop when held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (ctrl_wr && !hold_new) begin
            active_q <= 1'b1;
            cnt_q    <= RELOAD;
        end else if (expire) begin
            active_q <= !hold_q;
            cnt_q    <= RELOAD;
        end else if (active_q) begin
            cnt_q    <= cnt_q - 1'b1;
        end
    end

    AST_POLL_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active_q) |-> $past(hold_q)); // R11
    AST_POLL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |=> !poll_req); // R9
endmodule

// File: rtl/ring_halt_ctrl.sv
// Ring halt and stop controller top.
// Decodes register writes, keeps the halt flags and the control register,
// and turns status writes and poll expiries into walk requests. Tracks
// graceful stops per direction and provides a combinational read port.
// Assumes single-cycle writes, with one register per write.
module ring_halt_ctrl #(
    parameter int POLL_PERIOD = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [5:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic [7:0]  tx_halt_set,
    input  logic [7:0]  rx_halt_set,
    input  logic        tx_busy,
    input  logic        rx_busy,
    output logic        tx_walk_valid,
    output logic [2:0]  tx_walk_ring,
    output logic        rx_walk_valid,
    output logic [2:0]  rx_walk_ring,
    output logic        tx_stop_done,
    output logic        rx_stop_done
);
    import hs_pkg::*;

    localparam int RINGS = RING_CNT;
    localparam int RW    = RING_W;
    localparam int AW    = ADDR_W;

    logic wr_tx_base, wr_rx_base, wr_tstat, wr_rstat, wr_ctrl;
    logic [RINGS-1:0][DATA_W-1:0] tx_base, tx_ptr, rx_base, rx_ptr;
    logic [RINGS-1:0] tx_halt_q, rx_halt_q;
    logic [RINGS-1:0] tx_wr_bits, rx_wr_bits;
    logic [RINGS-1:0] tx_req, rx_req;
    ctl_t             ctl_q, ctl_new;
    logic             poll_req;

    // Write address decode.
    always_comb begin
        wr_tx_base = wr_en && (wr_addr[AW-1:RW] == A_TX_BASE[AW-1:RW]);
        wr_rx_base = wr_en && (wr_addr[AW-1:RW] == A_RX_BASE[AW-1:RW]);
        wr_tstat   = wr_en && (wr_addr == A_TX_STAT);
        wr_rstat   = wr_en && (wr_addr == A_RX_STAT);
        wr_ctrl    = wr_en && (wr_addr == A_CTRL);
        ctl_new    = ctl_t'(wr_data[CTL_W-1:0]);
    end

    // Map status data bits onto ring order.
    for (genvar i = 0; i < RINGS; i++) begin : g_bits
        assign tx_wr_bits[i] = wr_tstat && wr_data[TX_HALT_MSB - i];
        assign rx_wr_bits[i] = wr_rstat && wr_data[RX_HALT_MSB - i];
    end

    // Walk sources: tx kicks always, rx only on clear flags, plus the poll.
    always_comb begin
        tx_req = tx_wr_bits | {{(RINGS-1){1'b0}}, poll_req};
        rx_req = rx_wr_bits & ~rx_halt_q;
    end

    // Halt flags: set pulses win over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_halt_q <= '0;
            rx_halt_q <= '0;
        end else begin
            tx_halt_q <= (tx_halt_q & ~tx_wr_bits) | tx_halt_set;
            rx_halt_q <= (rx_halt_q & ~rx_wr_bits) | rx_halt_set;
        end
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else if (wr_ctrl) ctl_q <= ctl_new;
    end

    hs_ring_base #(.RINGS(RINGS), .DW(DATA_W)) u_tx_base (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_tx_base),
        .wr_idx(wr_addr[RW-1:0]), .wr_data(wr_data),
        .base_o(tx_base), .ptr_o(tx_ptr));

    hs_ring_base #(.RINGS(RINGS), .DW(DATA_W)) u_rx_base (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_rx_base),
        .wr_idx(wr_addr[RW-1:0]), .wr_data(wr_data),
        .base_o(rx_base), .ptr_o(rx_ptr));

    hs_poll_timer #(.PERIOD(POLL_PERIOD)) u_poll (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_ctrl),
        .hold_new(ctl_new.hold), .hold_q(ctl_q.hold),
        .tx_stop_q(ctl_q.tx_stop), .poll_req(poll_req));

    hs_walk_queue #(.RINGS(RINGS)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .req(tx_req),
        .walk_valid(tx_walk_valid), .walk_ring(tx_walk_ring));

    hs_walk_queue #(.RINGS(RINGS)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .req(rx_req),
        .walk_valid(rx_walk_valid), .walk_ring(rx_walk_ring));

    hs_stop_track u_tx_stop (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_ctrl),
        .stop_bit(ctl_new.tx_stop), .busy(tx_busy), .done_o(tx_stop_done));

    hs_stop_track u_rx_stop (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_ctrl),
        .stop_bit(ctl_new.rx_stop), .busy(rx_busy), .done_o(rx_stop_done));

    // Combinational read mux.
    always_comb begin
        rd_data = '0;
        if (rd_addr[AW-1:RW] == A_TX_BASE[AW-1:RW])     rd_data = tx_base[rd_addr[RW-1:0]];
        else if (rd_addr[AW-1:RW] == A_RX_BASE[AW-1:RW]) rd_data = rx_base[rd_addr[RW-1:0]];
        else if (rd_addr[AW-1:RW] == A_TX_PTR[AW-1:RW])  rd_data = tx_ptr[rd_addr[RW-1:0]];
        else if (rd_addr[AW-1:RW] == A_RX_PTR[AW-1:RW])  rd_data = rx_ptr[rd_addr[RW-1:0]];
        else if (rd_addr == A_TX_STAT) begin
            for (int i = 0; i < RINGS; i++) rd_data[TX_HALT_MSB - i] = tx_halt_q[i];
        end else if (rd_addr == A_RX_STAT) begin
            for (int i = 0; i < RINGS; i++) rd_data[RX_HALT_MSB - i] = rx_halt_q[i];
        end else if (rd_addr == A_CTRL) begin
            rd_data[CTL_W-1:0] = ctl_q;
        end
    end

    AST_HALT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tstat |=> ((tx_halt_q & $past(tx_wr_bits & ~tx_halt_set)) == '0)); // R5
endmodule

// File: tb/ring_halt_ctrl_bench.sv
`timescale 1ns/1ps
module ring_halt_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  tx_halt_set = '0;
    logic [7:0]  rx_halt_set = '0;
    logic        tx_busy = 1'b0;
    logic        rx_busy = 1'b0;
    logic        tx_walk_valid, rx_walk_valid, tx_stop_done, rx_stop_done;
    logic [2:0]  tx_walk_ring, rx_walk_ring;

    int total = 0;
    int failed = 0;
    int tx_n = 0, rx_n = 0, txd_n = 0, rxd_n = 0;
    logic [2:0] tx_log [0:63];
    logic [2:0] rx_log [0:63];

    always #2 clk = ~clk;

    ring_halt_ctrl u_ring_halt_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_halt_set(tx_halt_set), .rx_halt_set(rx_halt_set),
        .tx_busy(tx_busy), .rx_busy(rx_busy),
        .tx_walk_valid(tx_walk_valid), .tx_walk_ring(tx_walk_ring),
        .rx_walk_valid(rx_walk_valid), .rx_walk_ring(rx_walk_ring),
        .tx_stop_done(tx_stop_done), .rx_stop_done(rx_stop_done));

    // Output monitor, 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (tx_walk_valid) begin
            if (tx_n < 64) tx_log[tx_n] = tx_walk_ring;
            tx_n++;
        end
        if (rx_walk_valid) begin
            if (rx_n < 64) rx_log[rx_n] = rx_walk_ring;
            rx_n++;
        end
        if (tx_stop_done) txd_n++;
        if (rx_stop_done) rxd_n++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic clear_logs();
        tx_n = 0; rx_n = 0; txd_n = 0; rxd_n = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {waddr[75:70], wdata[69:38], raddr[37:32], expected[31:0]}
    localparam int NV = 6;
    localparam logic [75:0] VEC [0:NV-1] = '{
        {6'd3,  32'h1234_5677, 6'd3,  32'h1234_5670},
        {6'd0,  32'hCAFE_000F, 6'd16, 32'hCAFE_0008},
        {6'd15, 32'hFFFF_FFFF, 6'd31, 32'hFFFF_FFF8},
        {6'd19, 32'hAAAA_AAAA, 6'd19, 32'h1234_5670},
        {6'd10, 32'h0000_1003, 6'd10, 32'h0000_1000},
        {6'd40, 32'hFFFF_FFFF, 6'd40, 32'h0000_0000}
    };

    initial begin
        #800000;
        failed++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        wait_cyc(4);
        rst_n = 1'b1;

        // R12: reset state
        do_read(6'd0, d);  chk("R12 tx base reset", d, 32'h0);
        do_read(6'd34, d); chk("R12 ctrl reset", d, 32'h0);
        chk("R12 outputs idle", {28'h0, tx_walk_valid, rx_walk_valid, tx_stop_done, rx_stop_done}, 32'h0);
        clear_logs();
        wait_cyc(40);
        chk("R12 timer idle after reset", tx_n, 0);

        // R1 / R2 table
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = (i == 0 || i == 4 || i == 5) ? "R1 table" : "R2 table";
            do_write(VEC[i][75:70], VEC[i][69:38]);
            do_read(VEC[i][37:32], d);
            chk(tag, d, VEC[i][31:0]);
        end

        // R3 R5 R6: tx halt flag, multi-ring kick, ascending order
        clear_logs();
        @(negedge clk); tx_halt_set = 8'h02;
        @(negedge clk); tx_halt_set = 8'h00;
        do_read(6'd32, d); chk("R5 tx halt readback ring1", d, 32'h4000_0000);
        do_write(6'd32, 32'h6100_0000);
        chk("R6 first walk one cycle after write", {31'h0, tx_walk_valid}, 32'h0);
        @(negedge clk);
        chk("R6 first walk ring", {31'h0, tx_walk_valid}, 32'h1);
        wait_cyc(4);
        chk("R3 tx walk count", tx_n, 3);
        chk("R6 order 0", tx_log[0], 1);
        chk("R6 order 1", tx_log[1], 2);
        chk("R3 clear-flag ring walks", tx_log[2], 7);
        do_read(6'd32, d); chk("R5 tx flag cleared", d, 32'h0);

        // R4 R5: rx kicks only on clear flags
        clear_logs();
        @(negedge clk); rx_halt_set = 8'h08;
        @(negedge clk); rx_halt_set = 8'h00;
        do_read(6'd33, d); chk("R5 rx halt readback ring3", d, 32'h0010_0000);
        do_write(6'd33, 32'h0012_0000);
        wait_cyc(5);
        chk("R4 rx walk count", rx_n, 1);
        chk("R4 rx walk ring6 only", rx_log[0], 6);
        do_read(6'd33, d); chk("R5 rx flag cleared", d, 32'h0);
        clear_logs();
        do_write(6'd33, 32'h0010_0000);
        wait_cyc(4);
        chk("R4 rx ring3 walks once flag clear", {rx_n[28:0], rx_log[0]}, {29'd1, 3'd3});

        // R7: rx graceful stop
        clear_logs();
        rx_busy = 1'b0;
        do_write(6'd34, 32'h3);
        wait_cyc(3);
        chk("R7 rx stop immediate", rxd_n, 1);
        do_read(6'd34, d); chk("R7 ctrl readback", d, 32'h3);
        clear_logs();
        @(negedge clk); rx_busy = 1'b1;
        do_write(6'd34, 32'h3);
        wait_cyc(6);
        chk("R7 rx stop deferred while busy", rxd_n, 0);
        rx_busy = 1'b0;
        wait_cyc(3);
        chk("R7 rx stop at frame end", rxd_n, 1);

        // R8: tx graceful stop
        clear_logs();
        do_write(6'd34, 32'h5);
        wait_cyc(3);
        chk("R8 tx stop immediate", txd_n, 1);
        clear_logs();
        @(negedge clk); tx_busy = 1'b1;
        do_write(6'd34, 32'h5);
        wait_cyc(6);
        chk("R8 tx stop deferred while busy", txd_n, 0);
        tx_busy = 1'b0;
        wait_cyc(3);
        chk("R8 tx stop at frame end", txd_n, 1);
        chk("R12 no poll walks while held", tx_n, 0);

        // R9: poll timing
        do_write(6'd34, 32'h0);
        clear_logs();
        wait_cyc(16);
        chk("R9 no poll before period", tx_n, 0);
        wait_cyc(1);
        chk("R9 first poll walk", tx_n, 1);
        chk("R9 poll ring0", tx_log[0], 0);
        wait_cyc(16);
        chk("R9 second poll walk", tx_n, 2);

        // R13: poll expiry and tx ring0 kick on the same edge
        do_write(6'd34, 32'h0);
        clear_logs();
        wait_cyc(14);
        do_write(6'd32, 32'h8000_0000);
        wait_cyc(4);
        chk("R13 single ring0 walk", tx_n, 1);
        chk("R13 ring index", tx_log[0], 0);

        // R10: tx stop suppresses polls
        do_write(6'd34, 32'h4);
        clear_logs();
        wait_cyc(40);
        chk("R10 no poll walks under tx stop", tx_n, 0);

        // R11: hold bit stops the timer
        do_write(6'd34, 32'h0);
        do_write(6'd34, 32'h1);
        clear_logs();
        wait_cyc(60);
        chk("R11 no walks after hold", tx_n, 0);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule